// File: doc/BRIEF.md
# Privilege-Mode Banked Register File

This block is the general register file of a processor core whose exception modes each see their own copies of some architectural registers. The core presents a 4-bit architectural index on two read ports and one write port. The block turns each index into a physical storage slot using the bank of the current privilege mode. No data moves when the mode changes. Only the index translation changes, so a mode switch costs no extra cycles.

The block also holds the current status word, whose low five bits select the privilege mode. It keeps one saved-status register for each exception bank. The saved status of the current bank is always shown on a dedicated output and can be written through its own port. The unbanked modes have no saved status.

Top module: `bankreg_file`

## Requirements
- R1: After reset, all 16 architectural registers read 0 in every mode, all banked copies and saved-status registers are 0, and the status word is 32'h0000_001F (system mode).
- R2: The mode field is status bits [4:0]. The encodings are: user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011, system 5'b11111. User and system use the unbanked set. Any other value also uses the unbanked set.
- R3: Registers 0 to 7 and register 15 are a single copy shared by all modes.
- R4: Registers 8 to 12 have a private copy in fast-interrupt mode. All other modes share one copy.
- R5: Registers 13 and 14 have a private copy in each of the five banked modes. User and system share one copy.
- R6: Each banked mode has its own saved-status register. The saved-status output shows the one for the current bank.
- R7: In the unbanked set, saved-status writes are ignored and the saved-status output reads 0.
- R8: A status write takes effect at the next clock edge. A register or saved-status write in the same cycle uses the old mode's bank.
- R9: A register write is visible from the cycle after the edge. A read of the same index in the write cycle returns the old value, with no bypass.
- R10: A status write that keeps the same bank, including the same mode, changes only the status word. No register or saved-status content changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | New status word; bits [4:0] are the mode |
| stat_o | output | 32 | Current status word |
| sst_wr_en | input | 1 | Saved-status write enable for the current bank |
| sst_wr_data | input | 32 | Saved-status write data |
| sst_o | output | 32 | Saved status of the current bank (0 when unbanked) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural register index to write |
| wr_data | input | 32 | Register write data |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |

## Verification
The bench tests the two levels of aliasing. It writes registers 8 and 13 in one mode and reads them back in fast-interrupt mode, in another exception mode and in user mode. A mapping that banked registers 8 to 12 too widely, or not at all, would return the wrong copy. It also writes the status word and a register in the same cycle to expose a design that applies the new bank early. It reads a register during the cycle it is written to catch an illegal bypass. It loads an unknown mode encoding to make sure it falls back to the unbanked set instead of picking up an exception bank's stack pointer or saved status.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
    localparam int MODE_W = 5;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam int NARCH    = 16;
    localparam int IDX_W    = $clog2(NARCH);
    localparam int FIQ_CNT  = 5;
    localparam int NBANKED  = 5;
    localparam int NSLOT    = NARCH + FIQ_CNT + 2 * NBANKED;
    localparam int SLOT_W   = $clog2(NSLOT);

    localparam logic [IDX_W-1:0] IDX_FIQ_LO = 4'd8;
    localparam logic [IDX_W-1:0] IDX_FIQ_HI = 4'd12;
    localparam logic [IDX_W-1:0] IDX_SP     = 4'd13;
    localparam logic [IDX_W-1:0] IDX_LR     = 4'd14;

    typedef enum logic [2:0] {
        BANK_NONE = 3'd0,
        BANK_FIQ  = 3'd1,
        BANK_IRQ  = 3'd2,
        BANK_SVC  = 3'd3,
        BANK_ABT  = 3'd4,
        BANK_UND  = 3'd5
    } bank_e;

    function automatic bank_e bank_of(input logic [MODE_W-1:0] mode);
        case (mode)
            MODE_FIQ: return BANK_FIQ;
            MODE_IRQ: return BANK_IRQ;
            MODE_SVC: return BANK_SVC;
            MODE_ABT: return BANK_ABT;
            MODE_UND: return BANK_UND;
            default:  return BANK_NONE;
        endcase
    endfunction
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
    import bankreg_pkg::*;
(
    input  bank_e              bank_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [SLOT_W-1:0]  slot_o
);
    localparam int FIQ_BASE = NARCH;
    localparam int SPLR_BASE = NARCH + FIQ_CNT;

    always_comb begin
        slot_o = SLOT_W'(idx_i);
        if (bank_i == BANK_FIQ && idx_i >= IDX_FIQ_LO && idx_i <= IDX_FIQ_HI) begin
            slot_o = SLOT_W'(FIQ_BASE + int'(idx_i) - int'(IDX_FIQ_LO));
        end else if (bank_i != BANK_NONE && (idx_i == IDX_SP || idx_i == IDX_LR)) begin
            slot_o = SLOT_W'(SPLR_BASE + 2 * (int'(bank_i) - 1) + int'(idx_i) - int'(IDX_SP));
        end
    end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] rslot_a_i,
    input  logic [SLOT_W-1:0] rslot_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);
    typedef struct packed {
        logic [NSLOT-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && int'(wslot_i) < NSLOT) begin
            st_d.regs[wslot_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_a_o = (int'(rslot_a_i) < NSLOT) ? st_q.regs[rslot_a_i] : '0;
    assign rdata_b_o = (int'(rslot_b_i) < NSLOT) ? st_q.regs[rslot_b_i] : '0;

    // R9: written data lands in the addressed slot at the next edge
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> st_q.regs[$past(wslot_i)] == $past(wdata_i));
endmodule

// File: rtl/bankreg_sstat.sv
module bankreg_sstat
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [NBANKED:0][DATA_W-1:0] sst;
    } sst_t;

    sst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i && bank_i != BANK_NONE) begin
            s_d.sst[bank_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o = s_q.sst[bank_i];

    // R7: the unbanked slot is never written
    p_none_slot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sst[0] == '0);
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr_en,
    input  logic [31:0]       stat_wr_data,
    output logic [31:0]       stat_o,
    input  logic              sst_wr_en,
    input  logic [DATA_W-1:0] sst_wr_data,
    output logic [DATA_W-1:0] sst_o,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int NPORT = 3;
    localparam logic [31:0] STAT_RESET = 32'(MODE_SYS);

    typedef struct packed {
        logic [31:0] stat;
    } ctl_t;

    ctl_t c_d, c_q;
    bank_e bank;

    always_comb begin
        c_d = c_q;
        if (stat_wr_en) c_d.stat = stat_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q.stat <= STAT_RESET;
        else        c_q <= c_d;
    end

    assign stat_o = c_q.stat;
    assign bank   = bank_of(c_q.stat[MODE_W-1:0]);

    logic [NPORT-1:0][IDX_W-1:0]  port_idx;
    logic [NPORT-1:0][SLOT_W-1:0] port_slot;

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        bankreg_map u_map (
            .bank_i (bank),
            .idx_i  (port_idx[p]),
            .slot_o (port_slot[p])
        );
    end

    bankreg_store #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en),
        .wslot_i   (port_slot[2]),
        .wdata_i   (wr_data),
        .rslot_a_i (port_slot[0]),
        .rslot_b_i (port_slot[1]),
        .rdata_a_o (rd_a_data),
        .rdata_b_o (rd_b_data)
    );

    bankreg_sstat #(.DATA_W(DATA_W)) u_sstat (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_i  (bank),
        .we_i    (sst_wr_en),
        .wdata_i (sst_wr_data),
        .rdata_o (sst_o)
    );

    // R7: unbanked set shows zero saved status
    p_unbanked_sst_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank == BANK_NONE) |-> (sst_o == '0));

    // R8: status only changes through a status write
    p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr_en |=> $stable(stat_o));

    // R10: with no writes at all, a held read index returns held data
    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !stat_wr_en) |=> (!$stable(rd_a_idx) || $stable(rd_a_data)));

    // R9: a write with no mode change reads back next cycle on port A
    p_write_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !stat_wr_en) |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));
endmodule

// File: tb/test_bankreg_file.sv
module test_bankreg_file;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stat_wr_en = 1'b0;
    logic [31:0] stat_wr_data = '0;
    logic [31:0] stat_o;
    logic sst_wr_en = 1'b0;
    logic [W-1:0] sst_wr_data = '0;
    logic [W-1:0] sst_o;
    logic wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [W-1:0] wr_data = '0;
    logic [3:0] rd_a_idx = '0;
    logic [W-1:0] rd_a_data;
    logic [3:0] rd_b_idx = '0;
    logic [W-1:0] rd_b_data;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bankreg_file #(.DATA_W(W)) i_bankreg_file (
        .clk(clk), .rst_n(rst_n),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .stat_o(stat_o),
        .sst_wr_en(sst_wr_en), .sst_wr_data(sst_wr_data), .sst_o(sst_o),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
    );

    localparam logic [2:0] OP_MODE = 3'd0, OP_WREG = 3'd1, OP_WSST = 3'd2,
                           OP_CREG = 3'd3, OP_CSST = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  a;
        logic [31:0] d;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 47;
    localparam vec_t VECS [NVEC] = '{
        '{OP_WREG, 5'd0,  32'hA0, 4'd3},   // R3
        '{OP_WREG, 5'd8,  32'h08, 4'd4},   // R4
        '{OP_WREG, 5'd13, 32'h0D, 4'd5},   // R5
        '{OP_WREG, 5'd14, 32'h0E, 4'd5},   // R5
        '{OP_WREG, 5'd15, 32'h0F, 4'd3},   // R3
        '{OP_MODE, 5'h11, 32'h0,  4'd2},   // R2 fast interrupt
        '{OP_CREG, 5'd8,  32'h0,  4'd4},   // R4
        '{OP_CREG, 5'd13, 32'h0,  4'd5},   // R5
        '{OP_CREG, 5'd0,  32'hA0, 4'd3},   // R3
        '{OP_CREG, 5'd15, 32'h0F, 4'd3},   // R3
        '{OP_CSST, 5'd0,  32'h0,  4'd6},   // R6
        '{OP_WREG, 5'd8,  32'hF8, 4'd4},   // R4
        '{OP_WREG, 5'd13, 32'hFD, 4'd5},   // R5
        '{OP_WSST, 5'd0,  32'h5A, 4'd6},   // R6
        '{OP_MODE, 5'h12, 32'h0,  4'd2},   // R2 interrupt
        '{OP_CREG, 5'd8,  32'h08, 4'd4},   // R4
        '{OP_CREG, 5'd13, 32'h0,  4'd5},   // R5
        '{OP_CSST, 5'd0,  32'h0,  4'd6},   // R6
        '{OP_WREG, 5'd13, 32'h1D, 4'd5},   // R5
        '{OP_WSST, 5'd0,  32'h6A, 4'd6},   // R6
        '{OP_MODE, 5'h10, 32'h0,  4'd2},   // R2 user
        '{OP_CREG, 5'd13, 32'h0D, 4'd5},   // R5
        '{OP_CSST, 5'd0,  32'h0,  4'd7},   // R7
        '{OP_WSST, 5'd0,  32'h77, 4'd7},   // R7
        '{OP_CSST, 5'd0,  32'h0,  4'd7},   // R7
        '{OP_MODE, 5'h11, 32'h0,  4'd2},   // R2
        '{OP_CREG, 5'd8,  32'hF8, 4'd4},   // R4
        '{OP_CREG, 5'd13, 32'hFD, 4'd5},   // R5
        '{OP_CSST, 5'd0,  32'h5A, 4'd6},   // R6
        '{OP_MODE, 5'h12, 32'h0,  4'd2},   // R2
        '{OP_CREG, 5'd13, 32'h1D, 4'd5},   // R5
        '{OP_CSST, 5'd0,  32'h6A, 4'd6},   // R6
        '{OP_MODE, 5'h13, 32'h0,  4'd2},   // R2 supervisor
        '{OP_CREG, 5'd13, 32'h0,  4'd5},   // R5
        '{OP_CSST, 5'd0,  32'h0,  4'd6},   // R6
        '{OP_MODE, 5'h17, 32'h0,  4'd2},   // R2 abort
        '{OP_WREG, 5'd14, 32'h2E, 4'd5},   // R5
        '{OP_MODE, 5'h1B, 32'h0,  4'd2},   // R2 undefined
        '{OP_CREG, 5'd14, 32'h0,  4'd5},   // R5
        '{OP_MODE, 5'h17, 32'h0,  4'd2},   // R2
        '{OP_CREG, 5'd14, 32'h2E, 4'd5},   // R5
        '{OP_MODE, 5'h05, 32'h0,  4'd2},   // R2 unknown encoding
        '{OP_CREG, 5'd13, 32'h0D, 4'd2},   // R2
        '{OP_CREG, 5'd8,  32'h08, 4'd2},   // R2
        '{OP_CSST, 5'd0,  32'h0,  4'd2},   // R2
        '{OP_MODE, 5'h1F, 32'h0,  4'd2},   // R2 system
        '{OP_CREG, 5'd14, 32'h0E, 4'd5}    // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        stat_wr_en = 1'b0; sst_wr_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic read_both(input logic [3:0] idx);
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
    endtask

    task automatic set_mode(input logic [4:0] m);
        stat_wr_en = 1'b1; stat_wr_data = {27'd0, m};
        tick();
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 status", stat_o, 32'h1F);
        check("R1 saved status", sst_o, 32'h0);
        for (int i = 0; i < 16; i++) begin
            read_both(4'(i));
            check("R1 port A", rd_a_data, 32'h0);
            check("R1 port B", rd_b_data, 32'h0);
        end

        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d row %0d", VECS[v].req, v);
            case (VECS[v].op)
                OP_MODE: set_mode(VECS[v].a);
                OP_WREG: begin
                    wr_en = 1'b1; wr_idx = VECS[v].a[3:0]; wr_data = VECS[v].d;
                    tick();
                end
                OP_WSST: begin
                    sst_wr_en = 1'b1; sst_wr_data = VECS[v].d;
                    tick();
                end
                OP_CREG: begin
                    read_both(VECS[v].a[3:0]);
                    check(tag, rd_a_data, VECS[v].d);
                    check(tag, rd_b_data, VECS[v].d);
                end
                default: begin
                    #1;
                    check(tag, sst_o, VECS[v].d);
                end
            endcase
        end

        // R8: mode change and register write in the same cycle use the old bank
        stat_wr_en = 1'b1; stat_wr_data = 32'h11;
        wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h99;
        sst_wr_en = 1'b1; sst_wr_data = 32'h33;
        tick();
        read_both(4'd8);
        check("R8 fast bank r8 untouched", rd_a_data, 32'hF8);
        #1;
        check("R8 fast bank saved status untouched", sst_o, 32'h5A);
        set_mode(5'h1F);
        read_both(4'd8);
        check("R8 shared r8 took write", rd_a_data, 32'h99);

        // R10: same-mode and same-bank status writes
        stat_wr_en = 1'b1; stat_wr_data = 32'hF000_001F;
        tick();
        check("R10 status word", stat_o, 32'hF000_001F);
        read_both(4'd13);
        check("R10 r13 kept", rd_a_data, 32'h0D);
        read_both(4'd8);
        check("R10 r8 kept", rd_b_data, 32'h99);
        set_mode(5'h10);
        read_both(4'd14);
        check("R10 user sees system r14", rd_a_data, 32'h0E);

        // R9: read during write returns old value
        rd_a_idx = 4'd3;
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h55;
        #1;
        check("R9 no bypass", rd_a_data, 32'h0);
        tick();
        #1;
        check("R9 visible next cycle", rd_a_data, 32'h55);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule